// File: doc/BRIEF.md
# Credit-Based Link Flow Controller

This block carries flits across one point-to-point link without loss. A sender-side controller keeps a count of the free slots in the receiver's buffer. It accepts a flit from its stream input only while that count is nonzero. The flit then travels through a forward channel of fixed latency and lands in a receiver FIFO. A consumer drains the FIFO through a stream output. Each drained slot becomes a credit. The receiver collects freed slots and sends them back as one block credit message once a threshold is reached, or after a set number of quiet cycles if a partial block is still pending. The credit message crosses a return channel of fixed latency and is added to the sender's count.

Both stream edges follow valid/ready rules. A transfer happens on a rising clock edge where valid and ready are both high. At the input, `in_ready` is high exactly when the sender holds at least one credit, and it does not depend on `in_valid`. At the output, `out_valid` stays high and `out_data` stays unchanged while `out_ready` is low. The sender's credit count is also brought out as a plain status pin.

Top module: `credit_link_top`

## Requirements
- R1: After reset the credit count equals BUF_DEPTH, `in_ready` is high and `out_valid` is low.
- R2: `in_ready` is high exactly when the credit count is nonzero, so no flit is accepted with zero credits.
- R3: Every accepted flit takes one credit. At most BUF_DEPTH flits are accepted while nothing drains, and the receiver FIFO never receives a flit while it is full.
- R4: Flits come out in acceptance order with their data unchanged. With the FIFO empty, a flit accepted at one edge shows `out_valid` FWD_LAT edges later.
- R5: While `out_ready` is low, `out_valid` and `out_data` hold, and no credit returns to the sender.
- R6: When the number of pending freed slots reaches BLOCK, they return as one message worth BLOCK credits. The count jumps by BLOCK in a single cycle, CRD_LAT+1 edges after the completing drain.
- R7: A partial block that sees no drain for IDLE_TO cycles is flushed. One drain followed by silence raises the count by one, IDLE_TO+CRD_LAT+1 edges after the drain.
- R8: When a credit message arrives in the same cycle as an injection, the count changes by the returned amount minus one. Per cycle, the change plus the injections lies between 0 and BLOCK.
- R9: The credit count never exceeds BUF_DEPTH, and it returns to BUF_DEPTH once all flits are drained and the link has gone idle.
- R10: With BUF_DEPTH >= FWD_LAT+CRD_LAT+BLOCK+3, a continuous input stream with `out_ready` held high is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sender stream: flit offered |
| in_ready | output | 1 | Sender stream: a credit is available |
| in_data | input | FLIT_W | Sender stream: flit payload |
| out_valid | output | 1 | Receiver stream: FIFO holds a flit |
| out_ready | input | 1 | Receiver stream: consumer takes the head flit |
| out_data | output | FLIT_W | Receiver stream: head flit payload |
| tx_credits | output | clog2(BUF_DEPTH+1) | Sender credit count |

## Verification
Two events can fall in the same cycle: the sender injecting a flit and a credit message arriving from the return channel. The bench provokes this by sweeping the input valid and output ready patterns against each other, so credits keep coming back while the sender is still injecting. Every cycle, the bench takes the observed change in `tx_credits`, adds back the injection it saw, and requires the result to be between 0 and BLOCK. It also requires at least one cycle where an injection and an arrival coincide. After each run goes quiet, the count must be back at the buffer depth, which shows that no credit was lost or duplicated.

// File: rtl/clink_pkg.sv
package clink_pkg;
  // width of a counter that must hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/clink_pipe.sv
module clink_pipe #(
  parameter int W   = 8,
  parameter int LAT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  generate
    if (LAT == 0) begin : g_wire
      assign out_v = in_v;
      assign out_d = in_d;
    end else begin : g_regs
      logic [LAT-1:0] vld;
      logic [W-1:0]   dat [LAT];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld <= '0;
        else begin
          vld[0] <= in_v;
          for (int i = 1; i < LAT; i++) vld[i] <= vld[i-1];
        end
      end

      always_ff @(posedge clk) begin
        dat[0] <= in_d;
        for (int i = 1; i < LAT; i++) dat[i] <= dat[i-1];
      end

      assign out_v = vld[LAT-1];
      assign out_d = dat[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/clink_sender.sv
module clink_sender #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int BLOCK = 2,
  localparam int CW   = clink_pkg::cnt_w(DEPTH),
  localparam int BW   = clink_pkg::cnt_w(BLOCK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          tx_v,
  output logic [W-1:0]  tx_d,
  input  logic          crd_v,
  input  logic [BW-1:0] crd_n,
  output logic [CW-1:0] credits
);
  logic          fire;
  logic [CW:0]   nxt;

  assign in_ready = (credits != '0);
  assign fire     = in_valid && in_ready;
  assign tx_v     = fire;
  assign tx_d     = in_data;

  // returned credits minus the one taken this cycle
  always_comb begin
    nxt = (CW+1)'(credits) - (CW+1)'(fire);
    if (crd_v) nxt = nxt + (CW+1)'(crd_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credits <= CW'(DEPTH);
    else        credits <= nxt[CW-1:0];
  end

  p_credit_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(credits) <= DEPTH);
  p_consume_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !crd_v) |=> int'(credits) == int'($past(credits)) - 1);
  p_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && crd_v) |=>
      int'(credits) == int'($past(credits)) + int'($past(crd_n)) - 1);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !crd_v) |=> $stable(credits));
endmodule

// File: rtl/clink_fifo.sv
module clink_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH),
  localparam int CW   = clink_pkg::cnt_w(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         pop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ix, rd_ix;
  logic [CW-1:0] fill;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (fill != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ix];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ix] <= push_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ix <= '0;
      rd_ix <= '0;
      fill  <= '0;
    end else begin
      if (push) wr_ix <= bump(wr_ix);
      if (pop)  rd_ix <= bump(rd_ix);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> int'(fill) < DEPTH);
  p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/clink_crdret.sv
module clink_crdret #(
  parameter int BLOCK   = 2,
  parameter int IDLE_TO = 4,
  localparam int BW     = clink_pkg::cnt_w(BLOCK),
  localparam int IW     = clink_pkg::cnt_w(IDLE_TO)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic          crd_v,
  output logic [BW-1:0] crd_n
);
  logic [BW-1:0] acc;
  logic [BW-1:0] total;
  logic [IW-1:0] idle;

  assign total = acc + BW'(pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      idle  <= '0;
      crd_v <= 1'b0;
      crd_n <= '0;
    end else begin
      crd_v <= 1'b0;
      if (pop) begin
        idle <= '0;
        if (total >= BW'(BLOCK)) begin
          crd_v <= 1'b1;
          crd_n <= total;
          acc   <= '0;
        end else begin
          acc <= total;
        end
      end else if (acc != '0) begin
        if (idle == IW'(IDLE_TO - 1)) begin
          crd_v <= 1'b1;
          crd_n <= acc;
          acc   <= '0;
          idle  <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      end else begin
        idle <= '0;
      end
    end
  end

  p_block_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    crd_v |-> (crd_n != '0 && int'(crd_n) <= BLOCK));
  p_partial_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_v && int'(crd_n) < BLOCK) |-> $past(!pop));
  p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc) < BLOCK);
endmodule

// File: rtl/credit_link_top.sv
module credit_link_top #(
  parameter int FLIT_W    = 16,
  parameter int BUF_DEPTH = 16,
  parameter int FWD_LAT   = 3,
  parameter int CRD_LAT   = 3,
  parameter int BLOCK     = 4,
  parameter int IDLE_TO   = 8,
  localparam int CW       = clink_pkg::cnt_w(BUF_DEPTH),
  localparam int BW       = clink_pkg::cnt_w(BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_data,
  output logic [CW-1:0]     tx_credits
);
  logic              tx_v, rx_v, pop, ret_v, arr_v;
  logic [FLIT_W-1:0] tx_d, rx_d;
  logic [BW-1:0]     ret_n, arr_n;

  clink_sender #(.W(FLIT_W), .DEPTH(BUF_DEPTH), .BLOCK(BLOCK)) u_snd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx_v(tx_v), .tx_d(tx_d), .crd_v(arr_v),
    .crd_n(arr_n), .credits(tx_credits));

  clink_pipe #(.W(FLIT_W), .LAT(FWD_LAT)) u_fwd (
    .clk(clk), .rst_n(rst_n), .in_v(tx_v), .in_d(tx_d),
    .out_v(rx_v), .out_d(rx_d));

  clink_fifo #(.W(FLIT_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(rx_v), .push_d(rx_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .pop(pop));

  clink_crdret #(.BLOCK(BLOCK), .IDLE_TO(IDLE_TO)) u_ret (
    .clk(clk), .rst_n(rst_n), .pop(pop), .crd_v(ret_v), .crd_n(ret_n));

  clink_pipe #(.W(BW), .LAT(CRD_LAT)) u_back (
    .clk(clk), .rst_n(rst_n), .in_v(ret_v), .in_d(ret_n),
    .out_v(arr_v), .out_d(arr_n));
endmodule

// File: tb/test_credit_link_top.sv
module test_credit_link_top;
  localparam int W = 8, DEPTH = 8, FWD = 1, CRD = 1, BLOCK = 2, IDLE = 4;
  localparam int CW = clink_pkg::cnt_w(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, in_ready, out_valid;
  logic [W-1:0] in_data = '0, out_data;
  logic [CW-1:0] tx_credits;

  always #5 clk = ~clk;

  credit_link_top #(.FLIT_W(W), .BUF_DEPTH(DEPTH), .FWD_LAT(FWD),
    .CRD_LAT(CRD), .BLOCK(BLOCK), .IDLE_TO(IDLE)) i_credit_link_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .tx_credits(tx_credits));

  int total = 0, bad = 0;
  int fires = 0, stalls = 0, simul = 0, prev_cr = 0;
  bit prev_fire = 0, have_prev = 0, done = 0;
  logic [W-1:0] seq = '0;
  logic [W-1:0] sbq [$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit iv, input bit ordy);
    bit f;
    int d;
    @(negedge clk);
    in_valid = iv; in_data = seq; out_ready = ordy;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    if (have_prev) begin
      d = int'(tx_credits) - prev_cr + int'(prev_fire);
      chk(d >= 0 && d <= BLOCK, "R8 per-cycle credit change", d, BLOCK);
      if (prev_fire && d > 0) simul++;
    end
    chk(in_ready == (tx_credits != '0), "R2 ready tracks credits", int'(in_ready), int'(tx_credits != '0));
    chk(int'(tx_credits) <= DEPTH, "R9 credit ceiling", int'(tx_credits), DEPTH);
    f = iv && in_ready;
    if (iv && !in_ready) stalls++;
    if (f) begin sbq.push_back(seq); seq++; fires++; end
    if (out_valid && ordy) begin
      if (sbq.size() == 0) chk(0, "R4 unexpected flit", int'(out_data), -1);
      else begin
        logic [W-1:0] e;
        e = sbq.pop_front();
        chk(out_data == e, "R4 order and data", int'(out_data), int'(e));
      end
    end
    prev_cr = int'(tx_credits); prev_fire = f; have_prev = 1;
  endtask

  function automatic bit pat(input int mode, input int cyc, input bit rnd);
    case (mode)
      0: return 1'b1;
      1: return cyc[0];
      2: return rnd;
      default: return (cyc % 3) == 0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k, hold_d, base;
    bit saw_mid;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1 reset state
    chk(int'(tx_credits) == DEPTH, "R1 reset credits", int'(tx_credits), DEPTH);
    chk(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

    // R4 latency of one flit through an empty link
    step(1, 0);
    k = 0;
    do begin step(0, 0); k++; end while (!out_valid && k < 20);
    chk(k == FWD + 1, "R4 forward latency", k, FWD + 1);

    // R3 fill with nothing draining
    repeat (12) step(1, 0);
    chk(fires == DEPTH, "R3 accepted with no drain", fires, DEPTH);
    chk(tx_credits == '0, "R3 credits exhausted", int'(tx_credits), 0);
    chk(in_ready == 1'b0, "R2 ready low at zero", int'(in_ready), 0);

    // R5 hold under back-pressure, no credit returns
    hold_d = int'(out_data);
    repeat (10) step(0, 0);
    chk(out_valid && int'(out_data) == hold_d, "R5 head held", int'(out_data), hold_d);
    chk(tx_credits == '0, "R5 no credit without drain", int'(tx_credits), 0);

    // R7 single drain, partial flush after idle timeout
    step(0, 1);
    k = 0;
    do begin step(0, 0); k++; end while (tx_credits == '0 && k < 40);
    chk(k == IDLE + CRD + 2, "R7 flush timing", k, IDLE + CRD + 2);
    chk(int'(tx_credits) == 1, "R7 flushed amount", int'(tx_credits), 1);

    // R6 full block returns as one jump
    step(0, 1); step(0, 1);
    saw_mid = 0;
    k = 0;
    repeat (10) begin
      step(0, 0);
      if (int'(tx_credits) > 1 && int'(tx_credits) < 1 + BLOCK) saw_mid = 1;
      if (k == 0 && int'(tx_credits) == 1 + BLOCK) k = 1;
    end
    chk(int'(tx_credits) == 1 + BLOCK, "R6 block credited", int'(tx_credits), 1 + BLOCK);
    chk(saw_mid == 0, "R6 single-step jump", int'(saw_mid), 0);

    // drain and settle
    k = 0;
    while (sbq.size() > 0 && k < 200) begin step(0, 1); k++; end
    repeat (IDLE + FWD + CRD + 8) step(0, 0);
    chk(int'(tx_credits) == DEPTH, "R9 credits restored", int'(tx_credits), DEPTH);

    // sweep of input and output patterns
    for (int mi = 0; mi < 4; mi++) begin
      for (int mo = 0; mo < 4; mo++) begin
        int cyc, sent;
        cyc = 0; sent = 0; stalls = 0; base = fires;
        while (fires - base < 30 && cyc < 2000) begin
          step(pat(mi, cyc, lfsr[3]), pat(mo, cyc, lfsr[7]));
          cyc++;
        end
        sent = fires - base;
        chk(sent == 30, "R2 sweep injections", sent, 30);
        if (mi == 0 && mo == 0)
          chk(stalls == 0, "R10 full rate stream", stalls, 0);
        while (sbq.size() > 0 && cyc < 4000) begin
          step(0, pat(mo, cyc, lfsr[7]));
          cyc++;
        end
        repeat (IDLE + FWD + CRD + 8) step(0, 0);
        chk(sbq.size() == 0, "R4 all flits delivered", sbq.size(), 0);
        chk(int'(tx_credits) == DEPTH, "R9 conservation after run", int'(tx_credits), DEPTH);
      end
    end
    chk(simul > 0, "R8 injection with credit arrival seen", simul, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule